// File: doc/BRIEF.md
# Associative Processing Element Array with Per-Element Enable Stacks

This block is a row of small 8-bit processing elements that all follow one broadcast instruction stream in lockstep. Every cycle the controller presents one opcode together with a destination register index and an operand choice. The operand comes from a broadcast immediate, from a scalar value, or from the element's own register file. On a search, every element compares its selected register against the operand at the same time. Each element then pushes the result onto a private enable stack. Elements with a 1 on top of their stack are the responders. Only responders accept data instructions into their execute latch.

The array reports whether any responder exists and gives a one-hot pick of the lowest-indexed responder. A step instruction clears the picked element's top bit, so software can visit the responders one at a time. A data instruction with all responders enabled treats them in parallel. A single pick is a search followed by a step-free use of the one-hot select.

Data instructions pass through a one-entry execute latch per element and write the register file one cycle after issue. Searches and register operands forward the in-flight result, so back-to-back dependent instructions see sequential results.

Top module: `assoc_array`

## Requirements
- R1: While `rst` is high and right after it falls, every element is enabled (`top_mask_o` all ones), its stack is empty and all its registers read 0. `any_resp_o` is 1 and `first_sel_o` is 1 (element 0).
- R2: Opcode 1 (search) compares register `dst_i` of every element against its operand, whether the element is enabled or not. It pushes 1 on a match and 0 otherwise, and the result shows on `top_mask_o` after the issuing edge.
- R3: Opcode 4 loads the operand into register `dst_i`. Opcode 5 adds the operand modulo 256. Opcode 6 ANDs it in. The new value shows on `rd_data_o` one clock after the issuing edge. Element i's copy of register `rd_idx_i` sits at `rd_data_o[8*i +: 8]`.
- R4: An element whose top bit is 0 when a data opcode is issued leaves its registers unchanged.
- R5: The operand source is chosen by `src_i`: 0 is `imm_i`, 1 is `scalar_i`, 2 is the element's own register `src_reg_i`, and 3 is `imm_i`.
- R6: A search, or a register operand, that reads a register written by the instruction issued just before sees that instruction's result.
- R7: Opcode 2 (pop) removes the top entry and restores the previous enable state. A pop on an empty stack leaves the element enabled.
- R8: The stack holds 4 entries. A push onto a full stack discards the oldest entry, so after 5 searches 4 pops return the element to enabled.
- R9: `any_resp_o` is 1 exactly when at least one bit of `top_mask_o` is 1.
- R10: `first_sel_o` is one-hot on the lowest-indexed responder, and all zeros when there is no responder.
- R11: Opcode 3 (step) clears the top bit of the element picked by `first_sel_o`. On an empty stack it pushes a 0. With no responder it changes nothing.
- R12: Opcodes 0 and 7 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Broadcast opcode |
| dst_i | input | IDX_W | Destination or search register index |
| src_i | input | 2 | Operand source select |
| src_reg_i | input | IDX_W | Register index for a register operand |
| imm_i | input | 8 | Broadcast immediate |
| scalar_i | input | 8 | Scalar register value |
| rd_idx_i | input | IDX_W | Register index shown on rd_data_o |
| rd_data_o | output | 8*N | Register rd_idx_i of every element |
| top_mask_o | output | N | Top-of-stack bit of every element |
| any_resp_o | output | 1 | At least one responder |
| first_sel_o | output | N | One-hot lowest-indexed responder |

## Verification
The search is tried in four settings, each separating a different fault:
- Against per-element values built by stepping through responders one at a time, so a single element must match. This separates compare faults from mask faults.
- Against a register written by the instruction just before it, which exposes missing forwarding.
- Five deep in a row, so a stack that keeps the oldest entry instead of the newest ends on the wrong element.
- With no responders, which shows that data writes and steps are blocked.

A long random instruction mix with small immediates, which makes matches frequent, is compared every cycle with a behavioural model of registers and stacks.

// File: rtl/assoc_pkg.sv
package assoc_pkg;

    localparam int DATA_W = 8;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_SEARCH = 3'd1,
        OP_POP    = 3'd2,
        OP_STEP   = 3'd3,
        OP_LOAD   = 3'd4,
        OP_ADD    = 3'd5,
        OP_AND    = 3'd6,
        OP_RSV    = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        SRC_IMM    = 2'd0,
        SRC_SCALAR = 2'd1,
        SRC_REG    = 2'd2,
        SRC_IMM_B  = 2'd3
    } src_e;

    function automatic logic is_data_op(op_e op);
        return (op == OP_LOAD) || (op == OP_ADD) || (op == OP_AND);
    endfunction

    function automatic word_t alu_apply(op_e op, word_t cur, word_t opnd);
        word_t r;
        case (op)
            OP_ADD:  r = cur + opnd;
            OP_AND:  r = cur & opnd;
            default: r = opnd;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/assoc_mask_stack.sv
module assoc_mask_stack #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic push_i,
    input  logic push_bit_i,
    input  logic pop_i,
    input  logic clr_top_i,
    output logic top_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DEPTH-1:0] stk_q;
    logic [CNT_W-1:0] cnt_q;

    assign top_o = (cnt_q == '0) ? 1'b1 : stk_q[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            stk_q <= '0;
            cnt_q <= '0;
        end else if (push_i) begin
            stk_q <= {stk_q[DEPTH-2:0], push_bit_i};
            if (cnt_q != CNT_W'(DEPTH))
                cnt_q <= cnt_q + CNT_W'(1);
        end else if (pop_i) begin
            stk_q <= stk_q >> 1;
            if (cnt_q != '0)
                cnt_q <= cnt_q - CNT_W'(1);
        end else if (clr_top_i) begin
            stk_q[0] <= 1'b0;
            if (cnt_q == '0)
                cnt_q <= CNT_W'(1);
        end
    end
endmodule

// File: rtl/assoc_pe.sv
module assoc_pe
    import assoc_pkg::*;
#(
    parameter int IDX_W = 2,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  op_e              op_i,
    input  logic [IDX_W-1:0] dst_i,
    input  src_e             src_i,
    input  logic [IDX_W-1:0] src_reg_i,
    input  word_t            imm_i,
    input  word_t            scalar_i,
    input  logic             sel_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic             top_o,
    output word_t            rd_data_o
);
    localparam int NREG = 1 << IDX_W;

    typedef struct packed {
        logic             valid;
        op_e              op;
        logic [IDX_W-1:0] dst;
        word_t            opnd;
    } ex_latch_t;

    word_t     rf_q [NREG];
    ex_latch_t ex_q;
    word_t     ex_result;
    word_t     opnd;
    word_t     search_val;
    word_t     src_val;
    logic      match;

    assign ex_result = alu_apply(ex_q.op, rf_q[ex_q.dst], ex_q.opnd);

    // register read with forwarding from the execute latch
    always_comb begin
        src_val    = rf_q[src_reg_i];
        search_val = rf_q[dst_i];
        if (ex_q.valid && ex_q.dst == src_reg_i) src_val    = ex_result;
        if (ex_q.valid && ex_q.dst == dst_i)     search_val = ex_result;
    end

    always_comb begin
        case (src_i)
            SRC_SCALAR: opnd = scalar_i;
            SRC_REG:    opnd = src_val;
            default:    opnd = imm_i;
        endcase
    end

    assign match = (search_val == opnd);

    assoc_mask_stack #(.DEPTH(DEPTH)) u_stack (
        .clk        (clk),
        .rst        (rst),
        .push_i     (op_i == OP_SEARCH),
        .push_bit_i (match),
        .pop_i      (op_i == OP_POP),
        .clr_top_i  ((op_i == OP_STEP) && sel_i),
        .top_o      (top_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ex_q <= '0;
        end else begin
            ex_q.valid <= is_data_op(op_i) && top_o;
            ex_q.op    <= op_i;
            ex_q.dst   <= dst_i;
            ex_q.opnd  <= opnd;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NREG; r++) rf_q[r] <= '0;
        end else if (ex_q.valid) begin
            rf_q[ex_q.dst] <= ex_result;
        end
    end

    assign rd_data_o = rf_q[rd_idx_i];
endmodule

// File: rtl/assoc_first_pick.sv
module assoc_first_pick #(
    parameter int N = 8
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] sel_o,
    output logic         any_o
);
    logic [N:0] seen;

    always_comb begin
        seen[0] = 1'b0;
        for (int i = 0; i < N; i++) begin
            sel_o[i]    = req_i[i] & ~seen[i];
            seen[i + 1] = seen[i] | req_i[i];
        end
    end

    assign any_o = seen[N];
endmodule

// File: rtl/assoc_array.sv
module assoc_array
    import assoc_pkg::*;
#(
    parameter int N     = 8,
    parameter int DEPTH = 4,
    parameter int IDX_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        op_i,
    input  logic [IDX_W-1:0]  dst_i,
    input  logic [1:0]        src_i,
    input  logic [IDX_W-1:0]  src_reg_i,
    input  logic [7:0]        imm_i,
    input  logic [7:0]        scalar_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [8*N-1:0]    rd_data_o,
    output logic [N-1:0]      top_mask_o,
    output logic              any_resp_o,
    output logic [N-1:0]      first_sel_o
);
    op_e  op;
    src_e src;

    assign op  = op_e'(op_i);
    assign src = src_e'(src_i);

    for (genvar g = 0; g < N; g++) begin : g_pe
        assoc_pe #(.IDX_W(IDX_W), .DEPTH(DEPTH)) u_pe (
            .clk       (clk),
            .rst       (rst),
            .op_i      (op),
            .dst_i     (dst_i),
            .src_i     (src),
            .src_reg_i (src_reg_i),
            .imm_i     (imm_i),
            .scalar_i  (scalar_i),
            .sel_i     (first_sel_o[g]),
            .rd_idx_i  (rd_idx_i),
            .top_o     (top_mask_o[g]),
            .rd_data_o (rd_data_o[DATA_W*g +: DATA_W])
        );
    end

    assoc_first_pick #(.N(N)) u_pick (
        .req_i (top_mask_o),
        .sel_o (first_sel_o),
        .any_o (any_resp_o)
    );
endmodule

// File: rtl/assoc_array_chk.sv
module assoc_array_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [2:0]   op_i,
    input logic [N-1:0] top_mask_o,
    input logic         any_resp_o,
    input logic [N-1:0] first_sel_o
);
    // R1: reset leaves every element enabled
    a_r1_reset_enabled: assert property (@(posedge clk)
        rst |=> (top_mask_o == {N{1'b1}}));

    a_r10_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(first_sel_o));

    a_r10_pick_is_responder: assert property (@(posedge clk) disable iff (rst)
        (first_sel_o & ~top_mask_o) == '0);

    a_r9_any_agrees_pick: assert property (@(posedge clk) disable iff (rst)
        any_resp_o == (first_sel_o != '0));

    a_r11_step_clears_one: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd3 && any_resp_o) |=>
            ($countones(top_mask_o) == $countones($past(top_mask_o)) - 1));

    a_r12_nop_holds: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd0 || op_i == 3'd7) |=> $stable(top_mask_o));
endmodule

bind assoc_array assoc_array_chk #(.N(N)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .op_i        (op_i),
    .top_mask_o  (top_mask_o),
    .any_resp_o  (any_resp_o),
    .first_sel_o (first_sel_o)
);

// File: tb/tb_assoc_array.sv
module tb_assoc_array;
    localparam int N     = 8;
    localparam int DEPTH = 4;
    localparam int IDX_W = 2;
    localparam int NREG  = 1 << IDX_W;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [2:0]       op_i = '0;
    logic [IDX_W-1:0] dst_i = '0;
    logic [1:0]       src_i = '0;
    logic [IDX_W-1:0] src_reg_i = '0;
    logic [7:0]       imm_i = '0;
    logic [7:0]       scalar_i = '0;
    logic [IDX_W-1:0] rd_idx_i = '0;
    logic [8*N-1:0]   rd_data_o;
    logic [N-1:0]     top_mask_o;
    logic             any_resp_o;
    logic [N-1:0]     first_sel_o;

    always #5 clk = ~clk;

    assoc_array #(.N(N), .DEPTH(DEPTH), .IDX_W(IDX_W)) dut (.*);

    int checks = 0;
    int fails  = 0;
    int rd_ptr = 0;

    // behavioural reference model
    byte unsigned m_rf [N][NREG];
    bit           mq   [N][$];

    function automatic bit m_top(int i);
        return (mq[i].size() == 0) ? 1'b1 : mq[i][0];
    endfunction

    function automatic logic [N-1:0] m_tops();
        logic [N-1:0] t;
        for (int i = 0; i < N; i++) t[i] = m_top(i);
        return t;
    endfunction

    function automatic logic [N-1:0] m_first();
        logic [N-1:0] t = m_tops();
        for (int i = 0; i < N; i++) if (t[i]) return N'(1) << i;
        return '0;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic m_push(int i, bit b);
        mq[i].push_front(b);
        if (mq[i].size() > DEPTH) void'(mq[i].pop_back());
    endtask

    task automatic m_apply(int op, int dst, int src, int sreg, int imm, int scl);
        logic [N-1:0] t = m_tops();
        logic [N-1:0] f = m_first();
        for (int i = 0; i < N; i++) begin
            byte unsigned opnd;
            opnd = (src == 1) ? byte'(scl) : (src == 2) ? m_rf[i][sreg] : byte'(imm);
            case (op)
                1: m_push(i, m_rf[i][dst] == opnd);
                2: if (mq[i].size() > 0) void'(mq[i].pop_front());
                3: if (f[i]) begin
                       if (mq[i].size() == 0) mq[i].push_front(1'b0);
                       else mq[i][0] = 1'b0;
                   end
                4: if (t[i]) m_rf[i][dst] = opnd;
                5: if (t[i]) m_rf[i][dst] = m_rf[i][dst] + opnd;
                6: if (t[i]) m_rf[i][dst] = m_rf[i][dst] & opnd;
                default: ;
            endcase
        end
    endtask

    // drive one instruction at a falling edge, compare after the next rising edge
    task automatic issue(string req, int op, int dst, int src, int sreg, int imm, int scl);
        byte unsigned snap [N];
        int ridx = rd_ptr % NREG;
        rd_ptr++;
        op_i = 3'(op); dst_i = IDX_W'(dst); src_i = 2'(src);
        src_reg_i = IDX_W'(sreg); imm_i = 8'(imm); scalar_i = 8'(scl);
        rd_idx_i = IDX_W'(ridx);
        for (int i = 0; i < N; i++) snap[i] = m_rf[i][ridx];
        m_apply(op, dst, src, sreg, imm, scl);
        @(posedge clk);
        @(negedge clk);
        chk({req, " R2/R7 top_mask"}, 64'(top_mask_o), 64'(m_tops()));
        chk({req, " R9 any"}, 64'(any_resp_o), 64'(m_tops() != '0));
        chk({req, " R10 first_sel"}, 64'(first_sel_o), 64'(m_first()));
        for (int i = 0; i < N; i++)
            chk({req, " R3/R4 rd_data"}, 64'(rd_data_o[8*i +: 8]), 64'(snap[i]));
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        for (int i = 0; i < N; i++)
            for (int r = 0; r < NREG; r++) m_rf[i][r] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 top_mask", 64'(top_mask_o), 64'({N{1'b1}}));
        chk("R1 any", 64'(any_resp_o), 64'd1);
        chk("R1 first_sel", 64'(first_sel_o), 64'd1);
        chk("R1 rd_data", 64'(rd_data_o), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after release", 64'(top_mask_o), 64'({N{1'b1}}));

        // R11 and R3: step through responders, giving element i the value i+1 in r1
        for (int k = 0; k < N; k++) begin
            issue("R3 add", 5, 1, 0, 0, 1, 0);
            issue("R11 step", 3, 0, 0, 0, 0, 0);
        end
        chk("R9 none left", 64'(any_resp_o), 64'd0);
        chk("R10 none left", 64'(first_sel_o), 64'd0);
        issue("R11 step with no responder", 3, 0, 0, 0, 0, 0);
        issue("R4 masked load", 4, 1, 0, 0, 8'hEE, 0);
        issue("R4 masked observe", 0, 0, 0, 0, 0, 0);
        rd_ptr = 1;
        issue("R4 r1 unchanged", 0, 0, 0, 0, 0, 0);
        chk("R4 element 3 r1", 64'(rd_data_o[8*3 +: 8]), 64'd4);
        issue("R7 pop restores", 2, 0, 0, 0, 0, 0);
        chk("R7 all enabled", 64'(top_mask_o), 64'({N{1'b1}}));

        // R2 and R5
        issue("R2 search r1==3", 1, 1, 0, 0, 3, 0);
        chk("R2 single responder", 64'(top_mask_o), 64'h04);
        issue("R5 scalar load", 4, 2, 1, 0, 0, 8'h5A);
        issue("R5 settle", 0, 0, 0, 0, 0, 0);
        issue("R7 pop", 2, 0, 0, 0, 0, 0);
        issue("R5 register operand", 4, 3, 2, 1, 0, 0);
        issue("R6 search forwarded r3==5", 1, 3, 0, 0, 5, 0);
        chk("R6 forwarded search", 64'(top_mask_o), 64'h10);
        issue("R7 pop", 2, 0, 0, 0, 0, 0);
        issue("R6 load r0", 4, 0, 0, 0, 7, 0);
        issue("R6 add r0 to itself", 5, 0, 2, 0, 0, 0);
        rd_ptr = 0;
        issue("R6 observe", 0, 0, 0, 0, 0, 0);
        chk("R6 r0 doubled", 64'(rd_data_o[7:0]), 64'd14);
        issue("R5 imm via select 3", 6, 2, 3, 0, 8'h0F, 8'hFF);

        // R8: five pushes onto a four-deep stack
        for (int k = 1; k <= 5; k++) issue("R8 push", 1, 1, 0, 0, k, 0);
        chk("R8 top after 5 pushes", 64'(top_mask_o), 64'h10);
        for (int k = 0; k < 3; k++) issue("R8 pop", 2, 0, 0, 0, 0, 0);
        chk("R8 oldest kept is second search", 64'(top_mask_o), 64'h02);
        issue("R8 last pop", 2, 0, 0, 0, 0, 0);
        chk("R8 empty after 4 pops", 64'(top_mask_o), 64'({N{1'b1}}));
        issue("R7 pop on empty", 2, 0, 0, 0, 0, 0);
        chk("R7 empty pop enabled", 64'(top_mask_o), 64'({N{1'b1}}));

        // R12: reserved and no-op codes
        issue("R12 opcode 7", 7, 1, 2, 1, 9, 9);
        issue("R12 opcode 0", 0, 2, 1, 3, 9, 9);

        // random mix compared every cycle
        for (int k = 0; k < 600; k++) begin
            int op = $urandom_range(0, 7);
            issue("RND", op, $urandom_range(0, NREG - 1), $urandom_range(0, 3),
                  $urandom_range(0, NREG - 1), $urandom_range(0, 3), $urandom_range(0, 3));
        end
        summary();
    end
endmodule